// File: doc/BRIEF.md
# Four-Channel DMA Control Register Section

This block holds the shared control state of a four-channel DMA controller: the command byte, the software request bits, the per-channel mask, one mode byte per channel, the status byte and the byte-pointer flip-flop. A byte-wide register bus reaches it through eight control ports. The port index is `(addr >> PORT_SHIFT) & 0xF`, so a parameter sets how far apart the ports sit in the address map. `addr` is taken as the offset from the start of the control window.

Writes can load the command byte, raise or drop one channel's request, mask or unmask one channel, unmask every channel, load the whole mask vector, load one channel's mode, clear the byte pointer, or perform a master clear. A status read returns the request and terminal-count bits and then clears the terminal-count half. Terminal-count pulses from the transfer engine set status bits. The byte-pointer toggle input comes from the address and count registers, which are outside this block.

A two-state machine produces the re-arbitrate pulse. `RS_QUIET` moves to `RS_PULSE` on a write that changes the mask or the request bits. `RS_PULSE` stays in `RS_PULSE` when another such write arrives. Each state returns to `RS_QUIET` when no such write arrives. The `rearb` output is high only in `RS_PULSE`.

Top module: `dmac_ctrl_regs`

## Requirements
- R1: The port index is `(addr >> PORT_SHIFT) & 0xF`, and address bits outside those four are ignored. A write to an index from 8 to 15 changes no output. A read of such an index returns 0 and has no side effect.
- R2: A write to index 0 loads `cmd_q` when the data is zero or has no bit in common with `CMD_UNSUP_MASK` (default 8'hC3). Any other write to index 0 leaves `cmd_q` unchanged.
- R3: A write to index 1 takes channel c from data[1:0]. It sets `chan_req[c]` (status bit c+4) when data[2] is 1 and clears it when data[2] is 0.
- R4: A write to index 2 takes channel c from data[1:0]. It sets `chan_mask[c]` when data[2] is 1 and clears it when data[2] is 0.
- R5: A write to index 3 loads data[7:2] into the mode field of channel data[1:0], which is `chan_mode[6c+5:6c]`. Mode fields change at no other time.
- R6: A write to index 4, with any data, clears `byte_ptr`. `ptr_toggle` inverts `byte_ptr` each cycle it is high, and a clear in the same cycle wins over the toggle.
- R7: A write to index 5 clears `byte_ptr`, `cmd_q` and all status bits, and sets every mask bit. Reset does the same and also zeroes every mode field.
- R8: A write to index 6 clears every mask bit. A write to index 7 loads the mask from data[3:0].
- R9: A read of index 0 returns the status byte {request[3:0], tc[3:0]} and clears the tc half at the clock edge. A read of index 1 returns {4'b0, mask}. `rd_data` is 0 whenever `rd_en` is low.
- R10: `tc_in[i]` high at a clock edge sets status bit i. The bit stays set until a status read or a master clear, and a pulse in the same cycle as either of these still leaves the bit set.
- R11: `rearb` is high for exactly the cycle after each write to index 1, 2, 6 or 7, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Offset within the control window |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational, valid while `rd_en` is high |
| tc_in | input | 4 | Terminal-count pulse, one per channel |
| ptr_toggle | input | 1 | Inverts the byte pointer |
| chan_mask | output | 4 | Per-channel mask |
| chan_req | output | 4 | Per-channel software request |
| chan_mode | output | 24 | Six mode bits per channel, channel 0 lowest |
| cmd_q | output | 8 | Command register |
| byte_ptr | output | 1 | Byte-pointer flip-flop |
| rearb | output | 1 | One-cycle re-arbitrate pulse |

## Verification
The hardest cases are collisions in one cycle: a terminal-count pulse in the same cycle as the status read that clears it, and a pointer toggle in the same cycle as a pointer clear. Random stimulus seldom lines these up, so directed steps force each collision before a long random run. The bench's address generator fills the address bits outside the index with random values, and it shifts the index left by one, so the port spacing and the masking of the index are tested on every access.

// File: rtl/dmac_ctrl_pkg.sv
package dmac_ctrl_pkg;
    localparam int NUM_CH    = 4;
    localparam int DATA_W    = 8;
    localparam int CH_SEL_W  = $clog2(NUM_CH);
    localparam int MODE_W    = DATA_W - CH_SEL_W;
    localparam int NUM_PORTS = 8;

    typedef enum logic [2:0] {
        PI_CMD     = 3'd0,
        PI_REQ     = 3'd1,
        PI_SMASK   = 3'd2,
        PI_MODE    = 3'd3,
        PI_CLRFF   = 3'd4,
        PI_MCLR    = 3'd5,
        PI_CLRMASK = 3'd6,
        PI_WRMASK  = 3'd7
    } port_idx_e;

    typedef enum logic [0:0] {
        RS_QUIET = 1'b0,
        RS_PULSE = 1'b1
    } rearb_state_e;
endpackage

// File: rtl/dmac_port_decode.sv
module dmac_port_decode
    import dmac_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int PORT_SHIFT = 0
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr_en,
    input  logic                 rd_en,
    output logic [NUM_PORTS-1:0] wr_hit,
    output logic                 rd_status,
    output logic                 rd_mask
);
    logic [ADDR_W-1:0] shifted;
    logic [3:0]        idx;

    assign shifted = addr >> PORT_SHIFT;
    assign idx     = shifted[3:0];

    always_comb begin
        wr_hit    = '0;
        rd_status = 1'b0;
        rd_mask   = 1'b0;
        if (!idx[3]) begin
            if (wr_en) wr_hit[idx[2:0]] = 1'b1;
            rd_status = rd_en && (idx[2:0] == 3'd0);
            rd_mask   = rd_en && (idx[2:0] == 3'd1);
        end
    end
endmodule

// File: rtl/dmac_mode_bank.sv
module dmac_mode_bank
    import dmac_ctrl_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [CH_SEL_W-1:0]      sel,
    input  logic [MODE_W-1:0]        din,
    output logic [NUM_CH*MODE_W-1:0] mode_flat
);
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic [MODE_W-1:0] mode_q;
        always_ff @(posedge clk) begin
            if (!rst_n)                              mode_q <= '0;
            else if (we && sel == CH_SEL_W'(ch))     mode_q <= din;
        end
        assign mode_flat[ch*MODE_W +: MODE_W] = mode_q;
    end

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(mode_flat)); // R5
endmodule

// File: rtl/dmac_rearb_fsm.sv
module dmac_rearb_fsm
    import dmac_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic rearb
);
    rearb_state_e state_q, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RS_QUIET;
        else        state_q <= state_nx;
    end

    always_comb begin
        unique case (state_q)
            RS_QUIET: state_nx = trig ? RS_PULSE : RS_QUIET;
            RS_PULSE: state_nx = trig ? RS_PULSE : RS_QUIET;
        endcase
    end

    always_comb rearb = (state_q == RS_PULSE);
endmodule

// File: rtl/dmac_ctrl_regs.sv
module dmac_ctrl_regs
    import dmac_ctrl_pkg::*;
#(
    parameter int               ADDR_W         = 8,
    parameter int               PORT_SHIFT     = 0,
    parameter logic [DATA_W-1:0] CMD_UNSUP_MASK = 8'hC3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [DATA_W-1:0]        wr_data,
    output logic [DATA_W-1:0]        rd_data,
    input  logic [NUM_CH-1:0]        tc_in,
    input  logic                     ptr_toggle,
    output logic [NUM_CH-1:0]        chan_mask,
    output logic [NUM_CH-1:0]        chan_req,
    output logic [NUM_CH*MODE_W-1:0] chan_mode,
    output logic [DATA_W-1:0]        cmd_q,
    output logic                     byte_ptr,
    output logic                     rearb
);
    localparam int STAT_W = 2 * NUM_CH;

    logic [NUM_PORTS-1:0] wr_hit;
    logic                 rd_status, rd_mask;
    logic [STAT_W-1:0]    status_q, status_nx;
    logic [NUM_CH-1:0]    mask_q, mask_nx;
    logic [CH_SEL_W-1:0]  ch_sel;
    logic                 cmd_ok;
    logic                 arb_trig;
    logic                 ptr_q;

    dmac_port_decode #(.ADDR_W(ADDR_W), .PORT_SHIFT(PORT_SHIFT)) u_dec (
        .addr      (addr),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .wr_hit    (wr_hit),
        .rd_status (rd_status),
        .rd_mask   (rd_mask)
    );

    assign ch_sel = wr_data[CH_SEL_W-1:0];

    dmac_mode_bank u_modes (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (wr_hit[PI_MODE]),
        .sel       (ch_sel),
        .din       (wr_data[DATA_W-1:CH_SEL_W]),
        .mode_flat (chan_mode)
    );

    assign arb_trig = wr_hit[PI_REQ] | wr_hit[PI_SMASK] |
                      wr_hit[PI_CLRMASK] | wr_hit[PI_WRMASK];

    dmac_rearb_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (arb_trig),
        .rearb (rearb)
    );

    assign cmd_ok = (wr_data == '0) || ((wr_data & CMD_UNSUP_MASK) == '0);

    always_comb begin
        status_nx = status_q;
        if (rd_status)       status_nx[NUM_CH-1:0] = '0;
        if (wr_hit[PI_MCLR]) status_nx = '0;
        if (wr_hit[PI_REQ])  status_nx[NUM_CH + int'(ch_sel)] = wr_data[CH_SEL_W];
        status_nx[NUM_CH-1:0] = status_nx[NUM_CH-1:0] | tc_in;
    end

    always_comb begin
        mask_nx = mask_q;
        if (wr_hit[PI_SMASK])   mask_nx[ch_sel] = wr_data[CH_SEL_W];
        if (wr_hit[PI_MCLR])    mask_nx = '1;
        if (wr_hit[PI_CLRMASK]) mask_nx = '0;
        if (wr_hit[PI_WRMASK])  mask_nx = wr_data[NUM_CH-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            mask_q   <= '1;
            status_q <= '0;
            ptr_q    <= 1'b0;
        end else begin
            status_q <= status_nx;
            mask_q   <= mask_nx;
            if (wr_hit[PI_CLRFF] || wr_hit[PI_MCLR]) ptr_q <= 1'b0;
            else                                      ptr_q <= ptr_q ^ ptr_toggle;
            if (wr_hit[PI_CMD] && cmd_ok)  cmd_q <= wr_data;
            else if (wr_hit[PI_MCLR])      cmd_q <= '0;
        end
    end

    always_comb begin
        if (rd_status)    rd_data = status_q;
        else if (rd_mask) rd_data = {{(DATA_W-NUM_CH){1'b0}}, mask_q};
        else              rd_data = '0;
    end

    assign chan_mask = mask_q;
    assign chan_req  = status_q[STAT_W-1:NUM_CH];
    assign byte_ptr  = ptr_q;

    logic [ADDR_W-1:0] chk_shift;
    assign chk_shift = addr >> PORT_SHIFT;

    AST_CMD_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && chk_shift[3:0] == 4'd0 && wr_data != '0 && (wr_data & CMD_UNSUP_MASK) != '0)
        |=> $stable(cmd_q)); // R2
    AST_MCLR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && chk_shift[3:0] == 4'd5) |=> (chan_mask == '1 && cmd_q == '0 && !byte_ptr && chan_req == '0)); // R7
    AST_TC_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (|tc_in) |=> ((status_q[NUM_CH-1:0] & $past(tc_in)) == $past(tc_in))); // R10
    AST_TC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_status && !wr_hit[PI_MCLR]) |=>
        ((status_q[NUM_CH-1:0] & $past(status_q[NUM_CH-1:0])) == $past(status_q[NUM_CH-1:0]))); // R10
    AST_UNUSED_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && chk_shift[3]) |-> (rd_data == '0)); // R9
    AST_REARB_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !chk_shift[3] && (chk_shift[2:0] == 3'd1 || chk_shift[2:0] == 3'd2 ||
         chk_shift[2:0] == 3'd6 || chk_shift[2:0] == 3'd7)) |=> rearb); // R11
    AST_REARB_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rearb |-> $past(wr_en)); // R11
endmodule

// File: tb/dmac_ctrl_regs_test.sv
module dmac_ctrl_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [3:0]  tc_in = '0;
    logic        ptr_toggle = 1'b0;
    logic [3:0]  chan_mask, chan_req;
    logic [23:0] chan_mode;
    logic [7:0]  cmd_q;
    logic        byte_ptr, rearb;

    int n_tests = 0;
    int n_fail  = 0;

    logic [3:0] m_mask = 4'hF, m_req = '0, m_tc = '0;
    logic [7:0] m_cmd = '0;
    logic       m_ptr = 1'b0, m_rearb = 1'b0;
    logic [5:0] m_mode [4] = '{default: '0};

    always #10 clk = ~clk;

    dmac_ctrl_regs #(.ADDR_W(8), .PORT_SHIFT(1)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .tc_in(tc_in), .ptr_toggle(ptr_toggle),
        .chan_mask(chan_mask), .chan_req(chan_req), .chan_mode(chan_mode),
        .cmd_q(cmd_q), .byte_ptr(byte_ptr), .rearb(rearb)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [3:0] idx, input logic rd);
        if (!rd)            return 8'h00;
        else if (idx == 0)  return {m_req, m_tc};
        else if (idx == 1)  return {4'h0, m_mask};
        else                return 8'h00;
    endfunction

    function automatic logic cmd_accept(input logic [7:0] d);
        return (d == 8'h00) || ((d & 8'hC3) == 8'h00);
    endfunction

    task automatic step(input logic [3:0] idx, input logic wr, input logic rd,
                        input logic [7:0] d, input logic [3:0] tc, input logic tog,
                        input string tag);
        logic [31:0] r;
        logic [1:0]  c;
        r = $urandom;
        @(negedge clk);
        addr = {r[2:0], idx, r[3]};
        wr_en = wr; rd_en = rd; wr_data = d; tc_in = tc; ptr_toggle = tog;
        #1;
        chk(rd_data, exp_read(idx, rd), tag);
        chk(chan_mask, m_mask, "R8 mask");
        chk(chan_req, m_req, "R3 request");
        chk(cmd_q, m_cmd, "R2 command");
        chk(byte_ptr, m_ptr, "R6 pointer");
        chk(rearb, m_rearb, "R11 rearb");
        for (int ch = 0; ch < 4; ch++) chk(chan_mode[ch*6 +: 6], m_mode[ch], "R5 mode");
        c = d[1:0];
        if (rd && idx == 0) m_tc = '0;
        m_ptr = m_ptr ^ tog;
        if (wr) begin
            case (idx)
                4'd0: if (cmd_accept(d)) m_cmd = d;
                4'd1: m_req[c] = d[2];
                4'd2: m_mask[c] = d[2];
                4'd3: m_mode[c] = d[7:2];
                4'd4: m_ptr = 1'b0;
                4'd5: begin m_ptr = 1'b0; m_mask = 4'hF; m_req = '0; m_tc = '0; m_cmd = '0; end
                4'd6: m_mask = '0;
                4'd7: m_mask = d[3:0];
                default: ;
            endcase
        end
        m_tc = m_tc | tc;
        m_rearb = wr && (idx == 1 || idx == 2 || idx == 6 || idx == 7);
    endtask

    task automatic after_edge;
        @(posedge clk); #2;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'd20240);
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk(chan_mask, 4'hF, "R7 reset mask");
        chk(cmd_q, 8'h00, "R7 reset command");
        chk(chan_req, 4'h0, "R7 reset request");
        chk(chan_mode, 24'h0, "R7 reset modes");

        step(4'd0, 1, 0, 8'h3C, 4'h0, 0, "R2");
        step(4'd0, 1, 0, 8'h41, 4'h0, 0, "R2");
        after_edge(); chk(cmd_q, 8'h3C, "R2 reject unsupported");
        step(4'd0, 1, 0, 8'h00, 4'h0, 0, "R2");
        step(4'd1, 1, 0, 8'h06, 4'h0, 0, "R3");
        after_edge(); chk(chan_req, 4'b0100, "R3 set request");
        chk(rearb, 1'b1, "R11 pulse after request");
        step(4'd0, 0, 0, 8'h00, 4'b0001, 0, "R10");
        step(4'd0, 0, 1, 8'h00, 4'b0010, 0, "R9 status read");
        step(4'd0, 0, 1, 8'h00, 4'b0000, 0, "R10 tc kept across read");
        step(4'd0, 0, 1, 8'h00, 4'b0000, 0, "R9 cleared tc");
        step(4'd0, 0, 0, 8'h00, 4'h0, 1, "R6");
        step(4'd4, 1, 0, 8'hA5, 4'h0, 1, "R6");
        after_edge(); chk(byte_ptr, 1'b0, "R6 clear beats toggle");
        step(4'd9, 1, 0, 8'hFF, 4'h0, 0, "R1");
        step(4'd12, 0, 1, 8'h00, 4'h0, 0, "R1 unused read");
        step(4'd3, 1, 0, 8'hFD, 4'h0, 0, "R5");
        step(4'd7, 1, 0, 8'h05, 4'h0, 0, "R8");
        step(4'd2, 1, 0, 8'h07, 4'h0, 0, "R4");
        after_edge(); chk(chan_mask, 4'b1101, "R4 single mask set");
        step(4'd1, 0, 1, 8'h00, 4'h0, 0, "R9 mask read");
        step(4'd6, 1, 0, 8'h00, 4'h0, 0, "R8");
        step(4'd5, 1, 0, 8'h00, 4'b1000, 1, "R7");
        after_edge();
        chk(chan_mask, 4'hF, "R7 master clear mask");
        chk(byte_ptr, 1'b0, "R7 master clear pointer");
        chk(chan_req, 4'h0, "R7 master clear request");

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            logic [3:0]  idx;
            r = $urandom;
            idx = (r[1:0] == 2'd0) ? r[5:2] : {1'b0, r[4:2]};
            if (idx == 4'd5 && r[7:6] != 2'd0) idx = 4'd4;
            step(idx, r[8], r[10:9] == 2'd0, r[18:11],
                 (r[21:19] == 3'd0) ? r[25:22] : 4'h0, r[27:26] == 2'd0, "R9 random read");
        end
        step(4'd8, 0, 0, 8'h00, 4'h0, 0, "R9");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule